// File: doc/BRIEF.md
# UART fractional baud generator

This block derives the 16x oversampling tick of an asynchronous serial port from a fast bus clock. A 13-bit reload counter steps once per pulse from a prescale stage and emits one tick each time it wraps. The prescale stage works in one of two ways:

- **Fixed mode.** The clock is divided by 2 or by 3.
- **Fractional mode.** A 9-bit accumulator adds a programmed step value on every clock. Each carry out of the accumulator is one prescale pulse, so pulses arrive on average at step/512 of the clock rate.

Software programs the block through three write ports: a control word, the reload value and the fractional step. The safe way to retune is a fixed sequence. First clear the run bit, then write the new reload value, then set run again. While the generator runs, the reload value is frozen. When run goes high, the counter starts from a full reload, so the first tick arrives after one complete period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is 0, the run, fractional and select bits are 0, and the reload and step values are 0. Starting the generator with no reload write therefore ticks every 2 clocks.
- R2: In the control word, bit 15 is run, bit 13 is prescaler select (0 divides by 2, 1 divides by 3) and bit 11 is fractional enable. Each control write replaces all three bits at once, and every other bit of the word has no effect.
- R3: In fixed mode, `tick` is high once every P x (reload+1) clocks, where P is 2 or 3 as chosen by the select bit.
- R4: In fractional mode, a 9-bit accumulator starts at 0 and adds the step value on each running clock.
  - Running clock k (k = 1 is the first) carries when floor(k*step/512) > floor((k-1)*step/512).
  - `tick` is high in the cycle of every (reload+1)-th carry, so it may be high on consecutive cycles.
  - The select bit has no effect in this mode.
- R5: Let run be stored as 1 at clock edge c0. `tick` is then first high in the cycle after edge c0+k, where k = P x (reload+1) in fixed mode, or k is the clock of the (reload+1)-th carry in fractional mode.
- R6: `tick` is 0 in every cycle that follows a cycle in which run was 0. A later start begins from a cleared prescaler, a cleared accumulator and a full counter, not from where the stopped count left off.
- R7: A reload write is ignored in a cycle where run is 1, or where a control write in the same cycle sets run. The ticks keep their old period, and the old value is still in place at the next start.
- R8: Reload 0 gives one tick per prescale pulse. Reload 8191 gives one tick every 8192 x P clocks in fixed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWord | input | 16 | Control word: run bit 15, select bit 13, fractional bit 11 |
| reloadWe | input | 1 | Reload write strobe |
| reloadIn | input | 13 | Reload value, 0 to 8191 |
| fdvWe | input | 1 | Fractional step write strobe |
| fdvIn | input | 9 | Fractional step value |
| tick | output | 1 | One-cycle pulse at 16 times the baud rate |

## Verification
The bench runs each configuration from a fresh start and predicts, from R3 and R4 alone, the exact clock of every tick. This exposes both a wrong period and a wrong start phase.

- **Fixed mode.** Periods 8 and 9 separate the divide-by-2 path from the divide-by-3 path.
- **Fractional mode.**
  - Step 256 gives a regular carry pattern.
  - Step 453 gives an irregular pattern that only a correct accumulator reproduces.
  - Step 511 produces back-to-back ticks.
  - Step 1 produces a single carry per 512 clocks.
- **Reload writes and restarts.** A reload write in mid-run must leave the period intact. A stop in mid-period followed by a restart must not resume the old count.
- **Extremes and ignored bits.** Reload 0, reload 8191 and control words with every unrelated bit set cover the extremes and the bits that must be ignored.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Strobes that the control half hands to the datapath half.
  typedef struct packed {
    logic run;     // generator enabled
    logic fracEn;  // accumulator feeds the counter instead of the fixed divider
    logic divBy3;  // fixed divider ratio 3 instead of 2
  } genStrobes_t;

endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int RELOAD_W = 13,
  parameter int FDV_W    = 9,
  parameter int RUN_BIT  = 15,
  parameter int SEL_BIT  = 13,
  parameter int FRAC_BIT = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic                reloadWe,
  input  logic [RELOAD_W-1:0] reloadIn,
  input  logic                fdvWe,
  input  logic [FDV_W-1:0]    fdvIn,
  output genStrobes_t         strobes,
  output logic [RELOAD_W-1:0] reloadVal,
  output logic [FDV_W-1:0]    fdvVal
);

  logic                runQ;
  logic                fracQ;
  logic                selQ;
  logic [RELOAD_W-1:0] reloadQ;
  logic [FDV_W-1:0]    fdvQ;
  logic                reloadOpen;
  logic                unusedCtrlBits;

  // The reload accepts a write only while the generator is stopped and is not being started in the same cycle.
  assign reloadOpen     = !runQ && !(ctrlWe && ctrlWord[RUN_BIT]);
  assign unusedCtrlBits = ^ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      fracQ   <= 1'b0;
      selQ    <= 1'b0;
      reloadQ <= '0;
      fdvQ    <= '0;
    end else begin
      if (ctrlWe) begin
        runQ  <= ctrlWord[RUN_BIT];
        fracQ <= ctrlWord[FRAC_BIT];
        selQ  <= ctrlWord[SEL_BIT];
      end
      if (reloadWe && reloadOpen) reloadQ <= reloadIn;
      if (fdvWe) fdvQ <= fdvIn;
    end
  end

  always_comb begin
    strobes.run    = runQ;
    strobes.fracEn = fracQ;
    strobes.divBy3 = selQ;
  end

  assign reloadVal = reloadQ;
  assign fdvVal    = fdvQ;

  // R7: the reload value never moves across an edge at which the generator was running
  a_r7_reload_frozen: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(reloadQ));

endmodule

// File: rtl/baud_tick_prescale.sv
module baud_tick_prescale
  import baud_tick_pkg::*;
#(
  parameter int FDV_W   = 9,
  parameter int MAX_DIV = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobes_t      strobes,
  input  logic [FDV_W-1:0] fdvVal,
  output logic             preFire
);

  localparam int PRE_W = $clog2(MAX_DIV);
  localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(MAX_DIV - 1);
  localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(MAX_DIV - 2);

  logic [PRE_W-1:0] divCnt;
  logic [FDV_W-1:0] acc;
  logic [FDV_W:0]   accSum;
  logic             divFire;
  logic             fracFire;

  always_comb begin
    accSum   = {1'b0, acc} + {1'b0, fdvVal};
    fracFire = accSum[FDV_W];
    divFire  = divCnt >= (strobes.divBy3 ? LAST_SLOW : LAST_FAST);
    preFire  = strobes.run & (strobes.fracEn ? fracFire : divFire);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.run) begin
      divCnt <= '0;
      acc    <= '0;
    end else if (strobes.fracEn) begin
      divCnt <= '0;
      acc    <= accSum[FDV_W-1:0];
    end else begin
      divCnt <= divFire ? '0 : divCnt + 1'b1;
      acc    <= '0;
    end
  end

  // R3: in fixed mode two prescale pulses are never adjacent
  a_r3_fixed_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.fracEn && preFire) |=> (!preFire || strobes.fracEn));

endmodule

// File: rtl/baud_tick_datapath.sv
module baud_tick_datapath
  import baud_tick_pkg::*;
#(
  parameter int RELOAD_W = 13,
  parameter int FDV_W    = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  genStrobes_t         strobes,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic [FDV_W-1:0]    fdvVal,
  output logic                tick
);

  logic                preFire;
  logic [RELOAD_W-1:0] relCnt;
  logic                tickQ;
  logic                wrapNow;

  baud_tick_prescale #(.FDV_W(FDV_W), .MAX_DIV(3)) u_pre (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .fdvVal  (fdvVal),
    .preFire (preFire)
  );

  assign wrapNow = preFire && (relCnt == '0);

  // While stopped the counter is held at the reload value, so a start begins with a full period.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      relCnt <= '0;
      tickQ  <= 1'b0;
    end else if (!strobes.run) begin
      relCnt <= reloadVal;
      tickQ  <= 1'b0;
    end else begin
      tickQ <= wrapNow;
      if (preFire) relCnt <= wrapNow ? reloadVal : relCnt - 1'b1;
    end
  end

  assign tick = tickQ;

  // R8: the running count never exceeds the reload value
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobes.run |-> (relCnt <= reloadVal));

  // R5: the first running cycle starts from a full reload
  a_r5_full_period: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.run) |-> (relCnt == reloadVal));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int RELOAD_W = 13,
  parameter int FDV_W    = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic                reloadWe,
  input  logic [RELOAD_W-1:0] reloadIn,
  input  logic                fdvWe,
  input  logic [FDV_W-1:0]    fdvIn,
  output logic                tick
);

  genStrobes_t         strobes;
  logic [RELOAD_W-1:0] reloadVal;
  logic [FDV_W-1:0]    fdvVal;

  baud_tick_ctrl #(
    .CTRL_W   (CTRL_W),
    .RELOAD_W (RELOAD_W),
    .FDV_W    (FDV_W),
    .RUN_BIT  (15),
    .SEL_BIT  (13),
    .FRAC_BIT (11)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWord  (ctrlWord),
    .reloadWe  (reloadWe),
    .reloadIn  (reloadIn),
    .fdvWe     (fdvWe),
    .fdvIn     (fdvIn),
    .strobes   (strobes),
    .reloadVal (reloadVal),
    .fdvVal    (fdvVal)
  );

  baud_tick_datapath #(.RELOAD_W(RELOAD_W), .FDV_W(FDV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reloadVal (reloadVal),
    .fdvVal    (fdvVal),
    .tick      (tick)
  );

  // R6: a stopped cycle is always followed by a quiet tick output
  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> !tick);

endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic        reloadWe = 1'b0;
  logic [12:0] reloadIn = '0;
  logic        fdvWe = 1'b0;
  logic [8:0]  fdvIn = '0;
  logic        tick;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    expT;
  int    expQ[$];
  string tagNow = "R1 idle";

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .reloadWe(reloadWe), .reloadIn(reloadIn), .fdvWe(fdvWe), .fdvIn(fdvIn),
    .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares tick timing against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0] < cyc) begin
        check(1'b0, {tagNow, " missed tick"}, cyc, expQ[0]);
        void'(expQ.pop_front());
      end
      if (tick) begin
        if (expQ.size() == 0) check(1'b0, {tagNow, " unexpected tick"}, cyc, -1);
        else begin
          expT = expQ.pop_front();
          check(expT == cyc, tagNow, cyc, expT);
        end
      end
    end
  end

  // Write tasks are called at posedge+1 and return at posedge+1; c0 is the edge count after the write.
  task automatic wrCtrl(input bit run, input bit frac, input bit sel3, input bit junk, output int c0);
    logic [15:0] w;
    w = junk ? 16'h57FF : 16'h0000;
    w[15] = run; w[13] = sel3; w[11] = frac;
    ctrlWe = 1'b1; ctrlWord = w;
    @(posedge clk); #1;
    ctrlWe = 1'b0; ctrlWord = '0;
    c0 = cyc;
  endtask

  task automatic wrReload(input int v);
    reloadWe = 1'b1; reloadIn = 13'(v);
    @(posedge clk); #1;
    reloadWe = 1'b0;
  endtask

  task automatic wrFdv(input int v);
    fdvWe = 1'b1; fdvIn = 9'(v);
    @(posedge clk); #1;
    fdvWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // Driver: programs one configuration, pushes every predicted tick, runs M clocks, stops.
  task automatic runSeg(input bit frac, input bit sel3, input bit junk, input int fdv,
                        input int rel, input bit setRel, input int midRel, input int M,
                        input string tag);
    int c0;
    int dummy;
    int carries;
    bit fire;
    wrCtrl(1'b0, 1'b0, 1'b0, 1'b0, dummy);
    if (setRel) wrReload(rel);
    wrFdv(fdv);
    tagNow = tag;
    wrCtrl(1'b1, frac, sel3, junk, c0);
    carries = 0;
    for (int k = 1; k <= M; k++) begin
      if (frac) fire = ((longint'(k) * fdv) / 512) > ((longint'(k - 1) * fdv) / 512);
      else      fire = (k % (sel3 ? 3 : 2)) == 0;
      if (fire) begin
        carries++;
        if (carries % (rel + 1) == 0) expQ.push_back(c0 + k);
      end
    end
    if (midRel >= 0) begin
      while (cyc < c0 + M / 2) begin @(posedge clk); #1; end
      wrReload(midRel);
    end
    while (cyc < c0 + M - 1) begin @(posedge clk); #1; end
    wrCtrl(1'b0, 1'b0, 1'b0, 1'b0, dummy);
    tagNow = {tag, " R6 stopped"};
    idle(12);
    check(expQ.size() == 0, {tag, " leftover ticks"}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    check(1'b0, "watchdog expired", cyc, WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(20);
    check(tick == 1'b0, "R1 tick low after reset", int'(tick), 0);
    // R1: reload is 0 out of reset, so a bare start ticks every 2 clocks
    runSeg(1'b0, 1'b0, 1'b0, 0, 0, 1'b0, -1, 12, "R1 reset reload zero");
    // R3 and R2: divide by 2, unrelated control bits all set
    runSeg(1'b0, 1'b0, 1'b1, 0, 3, 1'b1, -1, 40, "R3 R2 div2 reload3");
    runSeg(1'b0, 1'b1, 1'b0, 0, 2, 1'b1, -1, 45, "R3 div3 reload2");
    runSeg(1'b0, 1'b0, 1'b0, 0, 0, 1'b1, -1, 10, "R8 div2 reload0");
    // R4: fractional patterns
    runSeg(1'b1, 1'b0, 1'b1, 256, 1, 1'b1, -1, 40, "R4 R2 frac256");
    runSeg(1'b1, 1'b0, 1'b0, 453, 4, 1'b1, -1, 200, "R4 frac453");
    runSeg(1'b1, 1'b1, 1'b0, 511, 0, 1'b1, -1, 30, "R4 R8 frac511 back-to-back");
    runSeg(1'b1, 1'b0, 1'b0, 1, 0, 1'b1, -1, 1100, "R4 frac1");
    // R7: reload write while running ignored, and old value kept for the next start
    runSeg(1'b0, 1'b0, 1'b0, 0, 3, 1'b1, 0, 40, "R7 write while running");
    runSeg(1'b0, 1'b0, 1'b0, 0, 3, 1'b0, -1, 24, "R7 value kept");
    // R5 and R6: stop mid-period, restart begins a full period
    runSeg(1'b0, 1'b1, 1'b0, 0, 4, 1'b1, -1, 20, "R5 partial period");
    runSeg(1'b0, 1'b1, 1'b0, 0, 4, 1'b0, -1, 20, "R6 restart fresh");
    // R8: largest reload
    runSeg(1'b0, 1'b0, 1'b0, 0, 8191, 1'b1, -1, 32770, "R8 reload max");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule